// File: doc/BRIEF.md
# Packed Pixel Distance Accumulator

This unit scores how closely two rows of pixels match. Each cycle it can take two 64-bit words. Each word packs eight unsigned 8-bit pixels. For every pixel position the unit forms the absolute difference between the two words. It adds the eight differences together and adds that total into a running error accumulator. A block-matching motion estimator streams a candidate block and a reference block through the unit, one word pair per cycle. It reads the accumulated distance when the last row has passed.

The datapath has two register stages. The first stage registers the eight lane differences. The second stage reduces them with an adder tree and updates the accumulator. A synchronous clear travels down the pipeline beside the data, so it lines up with the word it was issued with. Search control, choosing the best vector and fetching reference blocks are left to the surrounding logic.

Top module: `pix_sad_acc`

## Requirements
- R1: Lane i of each operand is bits [8i+7:8i] and is read as an unsigned value from 0 to 255.
- R2: Each lane contributes |a − b|. Swapping the two operands gives the same result.
- R3: The eight lane differences of an accepted word pair are summed, and that sum (at most 2040) is added to the accumulator.
- R4: A pair accepted with `in_valid` at clock edge k shows up in `acc_out` after edge k+1. `acc_valid` is high for exactly that one cycle.
- R5: Word pairs on consecutive cycles are each accumulated exactly once, with no idle cycle needed between them.
- R6: `clear` without `in_valid` at edge k makes `acc_out` zero after edge k+1.
- R7: `clear` with `in_valid` at edge k makes `acc_out` equal to that pair's sum alone. Any pair accepted before edge k is discarded.
- R8: The accumulator is ACC_W bits wide (32 by default) and wraps modulo 2^ACC_W on overflow.
- R9: When neither `in_valid` nor `clear` is high, the operand values have no effect and `acc_out` holds its value.
- R10: Synchronous active-low reset sets `acc_out` to zero and `acc_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The operand pair on this cycle is to be accumulated |
| clear | input | 1 | Start a new comparison: drop the accumulated value |
| op_a | input | 64 | Eight packed unsigned pixels, first operand |
| op_b | input | 64 | Eight packed unsigned pixels, second operand |
| acc_out | output | ACC_W | Accumulated distance |
| acc_valid | output | 1 | `acc_out` has just taken in one more word pair |

## Verification
On every cycle the assertions check five things:
- the two-cycle relation between `in_valid` and `acc_valid`;
- that the tree sum never exceeds eight times the lane maximum;
- that the accumulator holds steady when the pipeline carries neither data nor clear;
- that a lone clear leaves zero;
- the reset value.

Only the bench scenarios can show that the arithmetic is right. They cover the lane positions, operand order, back-to-back streams, clear issued with and without data, and wrap-around on a narrow instance.

// File: rtl/pix_sad_pkg.sv
// Shared sizing for the packed pixel distance accumulator.
// Assumes LANES is a power of two and ACC_W >= SUM_W.
package pix_sad_pkg;
    localparam int LANES  = 8;
    localparam int PIX_W  = 8;
    localparam int WORD_W = LANES * PIX_W;
    localparam int SUM_W  = PIX_W + $clog2(LANES);
    localparam int MAX_SUM = LANES * ((1 << PIX_W) - 1);
endpackage

// File: rtl/sad_absdiff_stage.sv
// Stage 1: per-lane absolute difference, registered together with the
// valid and clear flags so that they stay aligned with their data.
// Assumes unsigned lanes packed little-end first.
module sad_absdiff_stage #(
    parameter int LANES = 8,
    parameter int PIX_W = 8,
    localparam int WORD_W = LANES * PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              clear,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] diff_q,
    output logic              v_q,
    output logic              clr_q
);
    logic [WORD_W-1:0] diff_d;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PIX_W-1:0] la, lb;
        assign la = op_a[g*PIX_W +: PIX_W];
        assign lb = op_b[g*PIX_W +: PIX_W];
        // Larger minus smaller: never negative.
        assign diff_d[g*PIX_W +: PIX_W] = (la >= lb) ? (la - lb) : (lb - la);
    end

    // Capture the lane differences; data needs no reset.
    always_ff @(posedge clk) begin
        diff_q <= diff_d;
    end

    // Carry the control flags along with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            v_q   <= in_valid;
            clr_q <= clear;
        end
    end
endmodule

// File: rtl/sad_sum_tree.sv
// Combinational reduction of the lane differences into one sum.
// Assumes SUM_W is wide enough for LANES full-scale lanes.
module sad_sum_tree #(
    parameter int LANES = 8,
    parameter int PIX_W = 8,
    localparam int WORD_W = LANES * PIX_W,
    localparam int SUM_W  = PIX_W + $clog2(LANES)
) (
    input  logic [WORD_W-1:0] diff_i,
    output logic [SUM_W-1:0]  sum_o
);
    // Add every lane, zero-extended to the sum width.
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < LANES; i++) begin
            sum_o = sum_o + SUM_W'(diff_i[i*PIX_W +: PIX_W]);
        end
    end
endmodule

// File: rtl/sad_accum.sv
// Stage 2 register: the running error, cleared or added to as the
// stage 1 flags say; it wraps modulo 2^ACC_W.
// Assumes ACC_W >= SUM_W.
module sad_accum #(
    parameter int ACC_W   = 32,
    parameter int SUM_W   = 11,
    parameter int MAX_SUM = 2040
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic             clr_i,
    input  logic [SUM_W-1:0] sum_i,
    output logic [ACC_W-1:0] acc_q,
    output logic             acc_v_q
);
    logic [ACC_W-1:0] base, add;

    // Clear drops the old total; data on the same cycle still counts.
    always_comb begin
        base = clr_i ? '0 : acc_q;
        add  = v_i ? ACC_W'(sum_i) : '0;
    end

    // Update the running total and flag each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            acc_v_q <= 1'b0;
        end else begin
            acc_q   <= base + add;
            acc_v_q <= v_i;
        end
    end

    p_sum_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |-> (32'(sum_i) <= MAX_SUM));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!v_i && !clr_i) |=> $stable(acc_q));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !v_i) |=> (acc_q == '0));

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && !acc_v_q));
endmodule

// File: rtl/pix_sad_acc.sv
// Packed pixel distance accumulator: sum of absolute byte differences
// between two packed words, added into a running error. Two stages,
// one word pair per cycle, no back-pressure.
module pix_sad_acc #(
    parameter int ACC_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         clear,
    input  logic [pix_sad_pkg::WORD_W-1:0] op_a,
    input  logic [pix_sad_pkg::WORD_W-1:0] op_b,
    output logic [ACC_W-1:0]             acc_out,
    output logic                         acc_valid
);
    import pix_sad_pkg::*;

    logic [WORD_W-1:0] diff_s1;
    logic              v_s1, clr_s1;
    logic [SUM_W-1:0]  sum_s1;

    sad_absdiff_stage #(.LANES(LANES), .PIX_W(PIX_W)) u_diff (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear(clear),
        .op_a(op_a), .op_b(op_b),
        .diff_q(diff_s1), .v_q(v_s1), .clr_q(clr_s1));

    sad_sum_tree #(.LANES(LANES), .PIX_W(PIX_W)) u_tree (
        .diff_i(diff_s1), .sum_o(sum_s1));

    sad_accum #(.ACC_W(ACC_W), .SUM_W(SUM_W), .MAX_SUM(MAX_SUM)) u_acc (
        .clk(clk), .rst_n(rst_n), .v_i(v_s1), .clr_i(clr_s1),
        .sum_i(sum_s1), .acc_q(acc_out), .acc_v_q(acc_valid));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 acc_valid);

    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !acc_valid);
endmodule

// File: tb/pix_sad_acc_tb.sv
module pix_sad_acc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NARROW_W   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, clear = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [31:0] acc_out;
    logic        acc_valid;
    logic [NARROW_W-1:0] acc_n;
    logic        acc_n_valid;

    int errors = 0, checks = 0;
    logic [31:0]         exp_w = '0;
    logic [NARROW_W-1:0] exp_n = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_sad_acc u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .clear(clear), .op_a(op_a), .op_b(op_b),
        .acc_out(acc_out), .acc_valid(acc_valid));

    pix_sad_acc #(.ACC_W(NARROW_W)) u_narrow (.clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .clear(clear), .op_a(op_a), .op_b(op_b),
        .acc_out(acc_n), .acc_valid(acc_n_valid));

    function automatic int ref_sad(logic [63:0] a, logic [63:0] b);
        int s = 0;
        for (int i = 0; i < 8; i++) begin
            int x = int'(a[i*8 +: 8]);
            int y = int'(b[i*8 +: 8]);
            s += (x > y) ? x - y : y - x;
        end
        return s;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus and update the reference totals.
    task automatic drive(logic [63:0] a, logic [63:0] b, logic v, logic c);
        op_a = a; op_b = b; in_valid = v; clear = c;
        if (c) begin exp_w = '0; exp_n = '0; end
        if (v) begin
            exp_w = exp_w + 32'(ref_sad(a, b));
            exp_n = exp_n + NARROW_W'(ref_sad(a, b));
        end
        @(negedge clk);
    endtask

    task automatic idle();
        drive({$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 acc after reset", acc_out, 0);
        chk("R10 valid after reset", 32'(acc_valid), 0);
        rst_n = 1'b1;
        exp_w = '0; exp_n = '0;
    endtask

    task automatic t_single_lanes();
        // Only lane 7 differs: checks the lane position and the top byte.
        drive(64'hFF00_0000_0000_0000, 64'h0100_0000_0000_0000, 1'b1, 1'b0);
        chk("R4 valid not yet", 32'(acc_valid), 0);
        idle();
        chk("R4 valid after two edges", 32'(acc_valid), 1);
        chk("R1 lane 7 distance", acc_out, exp_w);
        idle();
        chk("R4 valid one cycle only", 32'(acc_valid), 0);
        drive(64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 1'b1, 1'b0);
        idle();
        chk("R3 eight lanes summed", acc_out, exp_w);
    endtask

    task automatic t_swap();
        drive(64'h0, 64'h0, 1'b0, 1'b1); idle();
        drive(64'h10F0_3377_0080_FF01, 64'hF010_7733_8000_01FF, 1'b1, 1'b0);
        idle();
        chk("R2 a-then-b", acc_out, exp_w);
        drive(64'h0, 64'h0, 1'b0, 1'b1);
        drive(64'hF010_7733_8000_01FF, 64'h10F0_3377_0080_FF01, 1'b1, 1'b0);
        idle();
        chk("R2 b-then-a", acc_out, exp_w);
    endtask

    task automatic t_back_to_back();
        int seen = 0;
        drive(64'h0, 64'h0, 1'b0, 1'b1); idle();
        for (int i = 0; i < 32; i++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, 1'b1, 1'b0);
            if (acc_valid) seen++;
        end
        idle(); if (acc_valid) seen++;
        idle(); if (acc_valid) seen++;
        chk("R5 stream total", acc_out, exp_w);
        chk("R5 one valid per word", 32'(seen), 32);
    endtask

    task automatic t_clear();
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0);
        drive(64'h0, 64'h0, 1'b0, 1'b1);
        idle();
        chk("R6 clear alone", acc_out, 0);
        drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h0, 1'b1, 1'b0);
        drive(64'h0102_0304_0506_0708, 64'h0, 1'b1, 1'b1);
        idle();
        chk("R7 clear with data", acc_out, 36);
        chk("R7 model agrees", exp_w, 36);
    endtask

    task automatic t_idle();
        logic [31:0] held;
        idle();
        held = acc_out;
        for (int i = 0; i < 4; i++) idle();
        chk("R9 idle holds", acc_out, held);
        chk("R9 idle no valid", 32'(acc_valid), 0);
    endtask

    task automatic t_wrap();
        drive(64'h0, 64'h0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++)
            drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0);
        idle();
        chk("R8 narrow wraps", 32'(acc_n), 2024);
        chk("R8 wide no wrap", acc_out, 6120);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single_lanes();
        t_swap();
        t_back_to_back();
        t_clear();
        t_idle();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule